// File: doc/BRIEF.md
# AC'97 Receive Slot Demultiplexer

This block sits on the receive side of an AC'97 link and runs on the bit clock. It finds each incoming frame from the rising edge of the frame sync, shifts in the serial data most significant bit first, and cuts the frame into a 16-bit tag followed by twelve 20-bit slots. The tag is published once per frame. Slots 1 and 2 carry the codec's register status address and status data, and they always go to a dedicated status output.

Each of slots 3 to 12 has its own 3-bit routing field in a route word. The field sends the slot to logical channel A, to logical channel B, or to no channel at all. A slot reaches a channel only when its valid bit in the tag of the same frame is set. Each channel has its own width select. The channel keeps the upper bits of the slot, right-justified, and holds one sample until the consumer acknowledges it. A sample that arrives while the previous one is still unread replaces it and raises the channel's overrun flag.

Top module: `ac97_slot_demux`

## Requirements
- R1: A frame starts on the first rising clock edge at which sync_i is sampled high after having been sampled low, and the sdata_i bit taken at that edge is the MSB of the tag. The tag (16 bits) is followed by slots 1 to 12 (20 bits each), all MSB first. A new sync rise in the middle of a frame abandons the old frame and starts a new one.
- R2: tag_o takes the tag, and tag_valid_o is high for exactly one cycle, right after the edge that samples tag bit 0 (frame bit 15).
- R3: stat_valid_o pulses for one cycle right after the edge that samples the last bit of slot 2, and only when tag bits 14 (slot 1) and 13 (slot 2) are both set. It then presents the slot 1 word on stat_addr_o and the slot 2 word on stat_data_o.
- R4: Slot s (3 to 12) is routed by route_i[3(s-3)+2 : 3(s-3)]. Code 1 selects channel A, code 2 selects channel B, and code 0 or any code from 3 to 7 drops the slot. Slots 0 to 2 never reach a channel.
- R5: A slot from 3 to 12 is delivered only when tag bit 15-s is set. Otherwise it produces no channel output.
- R6: The width code per channel is 0=10, 1=16, 2=18, 3=20 bits. The sample is the upper W bits of the slot, right-justified on the 20-bit data port, with zeros above.
- R7: A delivered sample sets valid and appears on data, with the slot number on slot_o. Valid goes high right after the edge that samples the slot's last bit, and it stays up with stable data until ack is sampled high.
- R8: A sample that arrives while valid is high and ack is low replaces the held sample and sets ovr. An ack clears both valid and ovr. A sample that arrives into an empty channel leaves ovr low.
- R9: While reset is asserted, all valid, pulse and overrun outputs are low and tag_o is zero.
- R10: Bits that arrive after slot 12 and before the next sync rise produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Frame sync |
| sdata_i | input | 1 | Serial receive data |
| route_i | input | 30 | Per-slot routing fields for slots 3..12 |
| a_width_i | input | 2 | Channel A width code |
| b_width_i | input | 2 | Channel B width code |
| a_ack_i | input | 1 | Channel A sample consumed |
| b_ack_i | input | 1 | Channel B sample consumed |
| tag_valid_o | output | 1 | One-cycle pulse: new tag |
| tag_o | output | 16 | Last received tag |
| stat_valid_o | output | 1 | One-cycle pulse: codec status received |
| stat_addr_o | output | 20 | Slot 1 word |
| stat_data_o | output | 20 | Slot 2 word |
| a_valid_o | output | 1 | Channel A sample held |
| a_data_o | output | 20 | Channel A sample |
| a_slot_o | output | 4 | Slot number of the channel A sample |
| a_ovr_o | output | 1 | Channel A overrun |
| b_valid_o | output | 1 | Channel B sample held |
| b_data_o | output | 20 | Channel B sample |
| b_slot_o | output | 4 | Slot number of the channel B sample |
| b_ovr_o | output | 1 | Channel B overrun |

## Verification
Counting from the edge that samples the first tag bit (edge 0), the tag pulse is due just after edge 15. A slot's status or channel result is due just after edge 16+20s-1, so slot 1 lands at edge 35, slot 2 at edge 55, and slot 12 at edge 255. The bench drives bits on the falling edge and records the cycle number at which each output event is seen on the following falling edge. It compares that number against the value computed from these positions, so a result that is a cycle early or late fails, and so does one with correct data. Held channel state (valid, overrun, data) is read at the falling edge after the ack edge.

// File: rtl/ac97_rx_pkg.sv
package ac97_rx_pkg;
  localparam int SLOT_W        = 20;
  localparam int TAG_W         = 16;
  localparam int FIRST_CH_SLOT = 3;
  localparam int LAST_SLOT     = 12;
  localparam int NUM_CH_SLOTS  = LAST_SLOT - FIRST_CH_SLOT + 1;
  localparam int FIELD_W       = 3;
  localparam int ROUTE_W       = FIELD_W * NUM_CH_SLOTS;
  localparam int SLOT_IDX_W    = $clog2(LAST_SLOT + 1);
  localparam int BIT_IDX_W     = $clog2(SLOT_W);
  localparam int NUM_CH        = 2;

  localparam logic [FIELD_W-1:0] CODE_A = 3'd1;
  localparam logic [FIELD_W-1:0] CODE_B = 3'd2;

  localparam logic [1:0] WSEL_10 = 2'd0;
  localparam logic [1:0] WSEL_16 = 2'd1;
  localparam logic [1:0] WSEL_18 = 2'd2;
  localparam logic [1:0] WSEL_20 = 2'd3;
endpackage

// File: rtl/ac97_rx_framer.sv
module ac97_rx_framer
  import ac97_rx_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sync_i,
  input  logic                  sdata_i,
  output logic                  slot_done_o,
  output logic [SLOT_IDX_W-1:0] slot_idx_o,
  output logic [SLOT_W-1:0]     slot_word_o
);
  logic                  sync_q, run_q;
  logic [SLOT_IDX_W-1:0] slot_q, cur_slot;
  logic [BIT_IDX_W-1:0]  bit_q, cur_bit;
  logic [SLOT_W-1:0]     shreg_q;
  logic                  start, active, last;

  assign start    = sync_i & ~sync_q;
  assign active   = start | run_q;
  assign cur_slot = start ? '0 : slot_q;
  assign cur_bit  = start ? '0 : bit_q;
  assign last     = active && (cur_bit == ((cur_slot == '0) ? BIT_IDX_W'(TAG_W - 1)
                                                             : BIT_IDX_W'(SLOT_W - 1)));

  assign slot_done_o = last;
  assign slot_idx_o  = cur_slot;
  assign slot_word_o = {shreg_q[SLOT_W-2:0], sdata_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= 1'b0;
      run_q   <= 1'b0;
      slot_q  <= '0;
      bit_q   <= '0;
      shreg_q <= '0;
    end else begin
      sync_q <= sync_i;
      if (active) begin
        shreg_q <= slot_word_o;
        if (last) begin
          bit_q <= '0;
          if (cur_slot == SLOT_IDX_W'(LAST_SLOT)) begin
            run_q  <= 1'b0;
            slot_q <= '0;
          end else begin
            run_q  <= 1'b1;
            slot_q <= cur_slot + 1'b1;
          end
        end else begin
          run_q  <= 1'b1;
          slot_q <= cur_slot;
          bit_q  <= cur_bit + 1'b1;
        end
      end
    end
  end

  // R1
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (run_q && slot_q == '0 && bit_q == BIT_IDX_W'(1)));

  // R10
  frame_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && cur_slot == SLOT_IDX_W'(LAST_SLOT)) |=> !run_q);
endmodule

// File: rtl/ac97_rx_status.sv
module ac97_rx_status
  import ac97_rx_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  slot_done_i,
  input  logic [SLOT_IDX_W-1:0] slot_idx_i,
  input  logic [SLOT_W-1:0]     slot_word_i,
  output logic                  tag_valid_o,
  output logic [TAG_W-1:0]      tag_o,
  output logic                  stat_valid_o,
  output logic [SLOT_W-1:0]     stat_addr_o,
  output logic [SLOT_W-1:0]     stat_data_o
);
  localparam int ADDR_BIT = TAG_W - 2;
  localparam int DATA_BIT = TAG_W - 3;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_valid_o  <= 1'b0;
      tag_o        <= '0;
      stat_valid_o <= 1'b0;
      stat_addr_o  <= '0;
      stat_data_o  <= '0;
    end else begin
      tag_valid_o  <= 1'b0;
      stat_valid_o <= 1'b0;
      if (slot_done_i) begin
        case (slot_idx_i)
          SLOT_IDX_W'(0): begin
            tag_o       <= slot_word_i[TAG_W-1:0];
            tag_valid_o <= 1'b1;
          end
          SLOT_IDX_W'(1): if (tag_o[ADDR_BIT]) stat_addr_o <= slot_word_i;
          SLOT_IDX_W'(2): if (tag_o[ADDR_BIT] && tag_o[DATA_BIT]) begin
            stat_data_o  <= slot_word_i;
            stat_valid_o <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // R2
  tag_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_valid_o |=> !tag_valid_o);

  // R3
  stat_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_valid_o |=> !stat_valid_o);

  // R3
  stat_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_valid_o |-> (tag_o[ADDR_BIT] && tag_o[DATA_BIT]));
endmodule

// File: rtl/ac97_rx_chan.sv
module ac97_rx_chan
  import ac97_rx_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  push_i,
  input  logic [SLOT_W-1:0]     word_i,
  input  logic [SLOT_IDX_W-1:0] slot_i,
  input  logic [1:0]            wsel_i,
  input  logic                  ack_i,
  output logic                  valid_o,
  output logic [SLOT_W-1:0]     data_o,
  output logic [SLOT_IDX_W-1:0] slot_o,
  output logic                  ovr_o
);
  logic [SLOT_W-1:0] trunc;

  always_comb begin
    case (wsel_i)
      WSEL_10: trunc = word_i >> (SLOT_W - 10);
      WSEL_16: trunc = word_i >> (SLOT_W - 16);
      WSEL_18: trunc = word_i >> (SLOT_W - 18);
      default: trunc = word_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      slot_o  <= '0;
      ovr_o   <= 1'b0;
    end else if (push_i) begin
      valid_o <= 1'b1;
      data_o  <= trunc;
      slot_o  <= slot_i;
      ovr_o   <= valid_o & ~ack_i;
    end else if (ack_i) begin
      valid_o <= 1'b0;
      ovr_o   <= 1'b0;
    end
  end

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !push_i && !ack_i) |=> (valid_o && $stable(data_o) && $stable(slot_o)));

  // R8
  ovr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && valid_o && !ack_i) |=> ovr_o);

  // R8
  ovr_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |-> valid_o);

  // R6
  width10_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && wsel_i == WSEL_10) |=> (data_o[SLOT_W-1:10] == '0));
endmodule

// File: rtl/ac97_slot_demux.sv
module ac97_slot_demux
  import ac97_rx_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sync_i,
  input  logic                  sdata_i,
  input  logic [ROUTE_W-1:0]    route_i,
  input  logic [1:0]            a_width_i,
  input  logic [1:0]            b_width_i,
  input  logic                  a_ack_i,
  input  logic                  b_ack_i,
  output logic                  tag_valid_o,
  output logic [TAG_W-1:0]      tag_o,
  output logic                  stat_valid_o,
  output logic [SLOT_W-1:0]     stat_addr_o,
  output logic [SLOT_W-1:0]     stat_data_o,
  output logic                  a_valid_o,
  output logic [SLOT_W-1:0]     a_data_o,
  output logic [SLOT_IDX_W-1:0] a_slot_o,
  output logic                  a_ovr_o,
  output logic                  b_valid_o,
  output logic [SLOT_W-1:0]     b_data_o,
  output logic [SLOT_IDX_W-1:0] b_slot_o,
  output logic                  b_ovr_o
);
  logic                  slot_done;
  logic [SLOT_IDX_W-1:0] slot_idx;
  logic [SLOT_W-1:0]     slot_word;
  logic [FIELD_W-1:0]    code;
  logic                  slot_ok;

  logic [NUM_CH-1:0]                 push, ack, valid, ovr;
  logic [NUM_CH-1:0][1:0]            wsel;
  logic [NUM_CH-1:0][SLOT_W-1:0]     data;
  logic [NUM_CH-1:0][SLOT_IDX_W-1:0] slot;

  ac97_rx_framer i_framer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sync_i      (sync_i),
    .sdata_i     (sdata_i),
    .slot_done_o (slot_done),
    .slot_idx_o  (slot_idx),
    .slot_word_o (slot_word)
  );

  ac97_rx_status i_status (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .slot_done_i  (slot_done),
    .slot_idx_i   (slot_idx),
    .slot_word_i  (slot_word),
    .tag_valid_o  (tag_valid_o),
    .tag_o        (tag_o),
    .stat_valid_o (stat_valid_o),
    .stat_addr_o  (stat_addr_o),
    .stat_data_o  (stat_data_o)
  );

  // Per-slot route field and tag valid bit; slots 0..2 match no field.
  always_comb begin
    code    = '0;
    slot_ok = 1'b0;
    for (int s = FIRST_CH_SLOT; s <= LAST_SLOT; s++) begin
      if (slot_idx == SLOT_IDX_W'(s)) begin
        code    = route_i[FIELD_W*(s-FIRST_CH_SLOT) +: FIELD_W];
        slot_ok = tag_o[TAG_W-1-s];
      end
    end
  end

  assign push[0] = slot_done && slot_ok && (code == CODE_A);
  assign push[1] = slot_done && slot_ok && (code == CODE_B);
  assign wsel[0] = a_width_i;
  assign wsel[1] = b_width_i;
  assign ack[0]  = a_ack_i;
  assign ack[1]  = b_ack_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ac97_rx_chan i_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push[c]),
      .word_i  (slot_word),
      .slot_i  (slot_idx),
      .wsel_i  (wsel[c]),
      .ack_i   (ack[c]),
      .valid_o (valid[c]),
      .data_o  (data[c]),
      .slot_o  (slot[c]),
      .ovr_o   (ovr[c])
    );
  end

  assign a_valid_o = valid[0];
  assign a_data_o  = data[0];
  assign a_slot_o  = slot[0];
  assign a_ovr_o   = ovr[0];
  assign b_valid_o = valid[1];
  assign b_data_o  = data[1];
  assign b_slot_o  = slot[1];
  assign b_ovr_o   = ovr[1];

  // R4
  ch_slot_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push[0] || push[1]) |-> (slot_idx >= SLOT_IDX_W'(FIRST_CH_SLOT)));
endmodule

// File: tb/test_ac97_slot_demux.sv
module test_ac97_slot_demux;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sync = 1'b0, sdata = 1'b0;
  logic [29:0] route = '0;
  logic [1:0]  a_width = 2'd3, b_width = 2'd3;
  logic        a_ack = 1'b0, b_ack = 1'b0;
  logic        tag_valid, stat_valid, a_valid, b_valid, a_ovr, b_ovr;
  logic [15:0] tag;
  logic [19:0] stat_addr, stat_data, a_data, b_data;
  logic [3:0]  a_slot, b_slot;

  ac97_slot_demux i_ac97_slot_demux (
    .clk_i(clk), .rst_ni(rst_ni), .sync_i(sync), .sdata_i(sdata), .route_i(route),
    .a_width_i(a_width), .b_width_i(b_width), .a_ack_i(a_ack), .b_ack_i(b_ack),
    .tag_valid_o(tag_valid), .tag_o(tag), .stat_valid_o(stat_valid),
    .stat_addr_o(stat_addr), .stat_data_o(stat_data),
    .a_valid_o(a_valid), .a_data_o(a_data), .a_slot_o(a_slot), .a_ovr_o(a_ovr),
    .b_valid_o(b_valid), .b_data_o(b_data), .b_slot_o(b_slot), .b_ovr_o(b_ovr));

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0, f_start = 0;
  bit auto_ack = 1'b1;
  logic [15:0] f_tag;
  logic [19:0] f_slot [13];

  int          tag_n, st_n;
  logic [15:0] tag_v [16];
  int          tag_c [16];
  logic [19:0] st_a [16], st_d [16];
  int          st_c [16];
  int          ch_n [2];
  logic [19:0] ch_d [2][16];
  logic [3:0]  ch_s [2][16];
  int          ch_c [2][16];

  always @(posedge clk) cyc <= cyc + 1;

  // Event monitor, away from the active edge
  always @(negedge clk) begin
    if (tag_valid) begin
      if (tag_n < 16) begin tag_v[tag_n] = tag; tag_c[tag_n] = cyc; end
      tag_n++;
    end
    if (stat_valid) begin
      if (st_n < 16) begin st_a[st_n] = stat_addr; st_d[st_n] = stat_data; st_c[st_n] = cyc; end
      st_n++;
    end
    if (auto_ack) begin
      if (a_valid && !a_ack) begin
        if (ch_n[0] < 16) begin ch_d[0][ch_n[0]] = a_data; ch_s[0][ch_n[0]] = a_slot; ch_c[0][ch_n[0]] = cyc; end
        ch_n[0]++;
        a_ack = 1'b1;
      end else a_ack = 1'b0;
      if (b_valid && !b_ack) begin
        if (ch_n[1] < 16) begin ch_d[1][ch_n[1]] = b_data; ch_s[1][ch_n[1]] = b_slot; ch_c[1][ch_n[1]] = cyc; end
        ch_n[1]++;
        b_ack = 1'b1;
      end else b_ack = 1'b0;
    end
  end

  task automatic chk_eq(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_log();
    tag_n = 0; st_n = 0; ch_n[0] = 0; ch_n[1] = 0;
  endtask

  task automatic set_slots(input logic [19:0] base);
    for (int s = 0; s < 13; s++) f_slot[s] = base ^ (20'h0B3C5 * 20'(s + 1));
  endtask

  function automatic logic bit_at(input int i);
    if (i < 16) return f_tag[15-i];
    return f_slot[(i-16)/20 + 1][19 - ((i-16) % 20)];
  endfunction

  task automatic send_frame(input int nbits, input int gap);
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      if (i == 0) f_start = cyc + 1;
      sync  = (i < 16);
      sdata = bit_at(i);
    end
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      sync  = 1'b0;
      sdata = i[0];
    end
  endtask

  function automatic int end_edge(input int s);
    return (s == 0) ? 15 : 16 + 20*s - 1;
  endfunction

  task automatic t_reset();
    chk_eq("R9", "valid/pulse outputs", {26'd0, tag_valid, stat_valid, a_valid, b_valid, a_ovr, b_ovr}, 32'd0);
    chk_eq("R9", "tag_o", tag, 16'h0);
  endtask

  task automatic t_basic();
    clear_log(); auto_ack = 1;
    route = 30'h9 | (30'd2 << 6); a_width = 2'd3; b_width = 2'd3;
    f_tag = 16'hFFF8; set_slots(20'hA5F31);
    send_frame(256, 6);
    chk_eq("R2", "tag count", tag_n, 1);
    chk_eq("R2", "tag value", tag_v[0], 16'hFFF8);
    chk_eq("R2", "tag cycle", tag_c[0], f_start + end_edge(0));
    chk_eq("R3", "status count", st_n, 1);
    chk_eq("R3", "status addr", st_a[0], f_slot[1]);
    chk_eq("R3", "status data", st_d[0], f_slot[2]);
    chk_eq("R3", "status cycle", st_c[0], f_start + end_edge(2));
    chk_eq("R4", "A count", ch_n[0], 2);
    chk_eq("R1", "A slot3 data", ch_d[0][0], f_slot[3]);
    chk_eq("R7", "A slot3 number", ch_s[0][0], 4'd3);
    chk_eq("R7", "A slot3 cycle", ch_c[0][0], f_start + end_edge(3));
    chk_eq("R1", "A slot4 data", ch_d[0][1], f_slot[4]);
    chk_eq("R7", "A slot4 cycle", ch_c[0][1], f_start + end_edge(4));
    chk_eq("R4", "B count", ch_n[1], 1);
    chk_eq("R4", "B slot5 data", ch_d[1][0], f_slot[5]);
    chk_eq("R7", "B slot5 number", ch_s[1][0], 4'd5);
    chk_eq("R7", "B slot5 cycle", ch_c[1][0], f_start + end_edge(5));
  endtask

  task automatic t_widths();
    route = 30'h1 | (30'd2 << 3); f_tag = 16'hFFF8;
    clear_log(); a_width = 2'd0; b_width = 2'd1; set_slots(20'hFEDCB);
    send_frame(256, 6);
    chk_eq("R6", "A width 10", ch_d[0][0], {10'd0, f_slot[3][19:10]});
    chk_eq("R6", "B width 16", ch_d[1][0], {4'd0, f_slot[4][19:4]});
    clear_log(); a_width = 2'd2; b_width = 2'd3; set_slots(20'h7F1E3);
    send_frame(256, 6);
    chk_eq("R6", "A width 18", ch_d[0][0], {2'd0, f_slot[3][19:2]});
    chk_eq("R6", "B width 20", ch_d[1][0], f_slot[4]);
  endtask

  task automatic t_tag_gate();
    clear_log(); a_width = 2'd3; b_width = 2'd3;
    route = 30'h1 | (30'd1 << 3) | (30'd2 << 6);
    f_tag = 16'h4000 | 16'h1000 | 16'h0400; set_slots(20'h31337);
    send_frame(256, 6);
    chk_eq("R3", "status suppressed (slot2 invalid)", st_n, 0);
    chk_eq("R5", "A count (slot4 invalid)", ch_n[0], 1);
    chk_eq("R5", "A slot number", ch_s[0][0], 4'd3);
    chk_eq("R5", "B count", ch_n[1], 1);
    chk_eq("R5", "B data", ch_d[1][0], f_slot[5]);
  endtask

  task automatic t_codes();
    logic [2:0] codes [10] = '{3'd3, 3'd4, 3'd5, 3'd6, 3'd7, 3'd0, 3'd3, 3'd5, 3'd7, 3'd2};
    clear_log(); route = '0;
    for (int k = 0; k < 10; k++) route[3*k +: 3] = codes[k];
    f_tag = 16'hFFF8; set_slots(20'h0C0DE);
    send_frame(256, 6);
    chk_eq("R4", "A count (codes 3..7 drop)", ch_n[0], 0);
    chk_eq("R4", "B count", ch_n[1], 1);
    chk_eq("R4", "B slot12 data", ch_d[1][0], f_slot[12]);
    chk_eq("R4", "B slot12 cycle", ch_c[1][0], f_start + end_edge(12));
  endtask

  task automatic t_overrun();
    @(negedge clk); auto_ack = 0; a_ack = 0; b_ack = 0;
    route = 30'h49; f_tag = 16'hFFF8; set_slots(20'h5A5A5);
    send_frame(256, 6);
    chk_eq("R8", "A valid after overrun", a_valid, 1'b1);
    chk_eq("R8", "A data is newest", a_data, f_slot[5]);
    chk_eq("R8", "A slot is newest", a_slot, 4'd5);
    chk_eq("R8", "A ovr set", a_ovr, 1'b1);
    repeat (10) @(negedge clk);
    chk_eq("R7", "A held without ack", {a_valid, a_data}, {1'b1, f_slot[5]});
    a_ack = 1'b1; @(negedge clk); a_ack = 1'b0;
    chk_eq("R7", "A valid cleared by ack", a_valid, 1'b0);
    chk_eq("R8", "A ovr cleared by ack", a_ovr, 1'b0);
    route = 30'h1; set_slots(20'h12345);
    send_frame(256, 6);
    chk_eq("R8", "single sample: valid", a_valid, 1'b1);
    chk_eq("R8", "single sample: no ovr", a_ovr, 1'b0);
    a_ack = 1'b1; @(negedge clk); a_ack = 1'b0; auto_ack = 1;
  endtask

  task automatic t_restart();
    clear_log(); route = 30'h1;
    f_tag = 16'hFFF8; set_slots(20'hBEEF1);
    send_frame(51, 0);
    f_tag = 16'h6000; set_slots(20'h4D2C1);
    send_frame(256, 6);
    chk_eq("R1", "tag count across restart", tag_n, 2);
    chk_eq("R1", "restarted tag value", tag_v[1], 16'h6000);
    chk_eq("R1", "restarted tag cycle", tag_c[1], f_start + end_edge(0));
    chk_eq("R1", "status count", st_n, 1);
    chk_eq("R1", "status addr of new frame", st_a[0], f_slot[1]);
    chk_eq("R1", "status cycle", st_c[0], f_start + end_edge(2));
    chk_eq("R5", "A none (slot3 invalid)", ch_n[0], 0);
  endtask

  task automatic t_idle();
    clear_log(); route = 30'h09249249; f_tag = 16'hFFF8; set_slots(20'h9E3B7);
    send_frame(256, 300);
    chk_eq("R10", "A count after idle bits", ch_n[0], 10);
    chk_eq("R10", "tag count after idle bits", tag_n, 1);
    chk_eq("R10", "status count after idle bits", st_n, 1);
    chk_eq("R4", "A last slot", ch_s[0][9], 4'd12);
  endtask

  initial begin
    clear_log();
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    t_basic();
    t_widths();
    t_tag_gate();
    t_codes();
    t_overrun();
    t_restart();
    t_idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule